// File: doc/BRIEF.md
# Multi-Buffer Receive Message Allocator

This block sits behind a frame receiver and decides which of sixteen message buffers keeps each incoming frame. Every buffer has software-set configuration: a buffer type, an 11-bit identifier, a mask selector and an interrupt-enable bit. Buffers that agree on type and mask selector, and whose identifiers agree once the selected mask is applied, form one receive group by themselves. There is no enable for this grouping. A frame that matches the group is written into the group's buffers in rising index order. A buffer holding unread data is never overwritten.

Each stored buffer raises a data-new flag, which the host clears through a write-one-to-clear vector. The group does not wrap. Once its highest buffer holds data, further matching frames are dropped until the host has cleared every flag in the group. A dropped frame is never moved to another group. The host reads a buffer's identifier, length code and payload through an index-addressed read port. A per-buffer interrupt-enable turns a store into a one-cycle completion pulse. Software can use it to signal that a group is full (enable on the top buffer) or close to full (enable on the buffer below the top).

Top module: `mbrb_rx_alloc`

## Requirements
- R1: After reset, every data-new flag is 0, the interrupt vector is 0, and every buffer has type 0. No frame is stored until buffers are configured.
- R2: A buffer whose type is 0 is unused. It never receives a frame, whatever its identifier.
- R3: The mask selector works as follows. Value 0 means no mask. Values 1 to 4 pick mask register 0 to 3. A mask bit of 1 makes that identifier bit don't-care. A buffer matches a frame when the frame identifier and the buffer identifier agree on every bit that is not masked. Buffers with equal nonzero type, equal mask selector and identifiers that agree under that mask form one group.
- R4: A frame sampled with `rx_valid` is written into the lowest group buffer that is free and lies above every group buffer holding data. The buffer's data-new flag reads 1 in the cycle after the strobe. At most one buffer is written per frame.
- R5: When the group's highest buffer holds data, a matching frame is dropped, even if lower buffers of the group have been cleared.
- R6: When the host has cleared every data-new flag of a group, the next matching frame goes to the group's lowest buffer.
- R7: A frame dropped because its group is full is not written to any other group, even one of a different type whose identifier matches.
- R8: When buffers of several groups match a frame, the group that holds the lowest-numbered matching buffer receives it.
- R9: Storing into buffer j pulses bit j of `rx_irq` for exactly one cycle, in the cycle after the strobe, if that buffer's interrupt enable is 1. Otherwise `rx_irq` stays 0.
- R10: Writing 1 to bit j of `dn_clr` clears data-new flag j at the next edge. If a store to buffer j lands in the same cycle, the flag ends up set.
- R11: The read port returns the identifier, 4-bit length code and 64-bit payload last stored into buffer `rd_idx`. While the buffer's data-new flag stays set, its contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for one buffer's configuration |
| cfg_idx | input | 4 | Buffer being configured |
| cfg_type | input | 3 | Buffer type, 0 = unused |
| cfg_id | input | 11 | Buffer identifier |
| cfg_msel | input | 3 | Mask selector (0 none, 1..4 mask register 0..3) |
| cfg_ie | input | 1 | Interrupt enable for the buffer |
| mask_we | input | 1 | Write strobe for a mask register |
| mask_idx | input | 2 | Mask register index |
| mask_val | input | 11 | Mask value, 1 = ignore bit |
| dn_clr | input | 16 | Write-one-to-clear for the data-new flags |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 11 | Frame identifier |
| rx_len | input | 4 | Frame length code |
| rx_data | input | 64 | Frame payload |
| rd_idx | input | 4 | Buffer selected for read-back |
| rd_id | output | 11 | Stored identifier of the selected buffer |
| rd_len | output | 4 | Stored length code of the selected buffer |
| rd_data | output | 64 | Stored payload of the selected buffer |
| dn_vec | output | 16 | Data-new flags |
| rx_irq | output | 16 | One-cycle completion pulses, one bit per buffer |

## Verification
The bench fills a four-buffer group to the top, then frees only its lowest buffer. A design that wraps like a ring would store into that buffer, and one that spills into a free group of another type with the same identifier would store into that group. Both show up as an unexpected data-new rise. It then clears the remaining flags and expects the lowest buffer again. It also clears a middle buffer and expects the next frame above it, which catches a lowest-free-first search. Masked grouping is checked with a buffer whose raw identifier differs, and with a frame that falls just outside the mask. Two overlapping groups check the priority rule. A store that coincides with a clear of the same flag checks that a design letting the clear win would lose the frame.

// File: rtl/mbrb_pkg.sv
package mbrb_pkg;
  localparam int ID_W   = 11;
  localparam int TYPE_W = 3;
  localparam int MSEL_W = 3;
  localparam int LEN_W  = 4;

  typedef struct packed {
    logic [TYPE_W-1:0] btype;
    logic [ID_W-1:0]   id;
    logic [MSEL_W-1:0] msel;
    logic              ie;
  } bcfg_t;
endpackage

// File: rtl/mbrb_cfg_regs.sv
module mbrb_cfg_regs
  import mbrb_pkg::*;
#(
  parameter int NBUF  = 16,
  parameter int NMASK = 4,
  localparam int IDX_W  = $clog2(NBUF),
  localparam int MIDX_W = (NMASK > 1) ? $clog2(NMASK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  bcfg_t             cfg_in,
  input  logic              mask_we,
  input  logic [MIDX_W-1:0] mask_idx,
  input  logic [ID_W-1:0]   mask_val,
  output logic [TYPE_W-1:0] btype    [NBUF],
  output logic [ID_W-1:0]   bid      [NBUF],
  output logic [MSEL_W-1:0] bmsel    [NBUF],
  output logic [ID_W-1:0]   eff_mask [NBUF],
  output logic [NBUF-1:0]   ie_vec
);
  bcfg_t           cfg_q  [NBUF];
  bcfg_t           cfg_d  [NBUF];
  logic [ID_W-1:0] mask_q [NMASK];
  logic [ID_W-1:0] mask_d [NMASK];

  // next-state
  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      cfg_d[i] = cfg_q[i];
      if (cfg_we && (cfg_idx == IDX_W'(i))) cfg_d[i] = cfg_in;
    end
    for (int m = 0; m < NMASK; m++) begin
      mask_d[m] = mask_q[m];
      if (mask_we && (mask_idx == MIDX_W'(m))) mask_d[m] = mask_val;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) cfg_q[i] <= '0;
      for (int m = 0; m < NMASK; m++) mask_q[m] <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) cfg_q[i] <= cfg_d[i];
      for (int m = 0; m < NMASK; m++) mask_q[m] <= mask_d[m];
    end
  end

  // field fan-out and mask resolution per buffer
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign btype[i]  = cfg_q[i].btype;
    assign bid[i]    = cfg_q[i].id;
    assign bmsel[i]  = cfg_q[i].msel;
    assign ie_vec[i] = cfg_q[i].ie;
    always_comb begin
      eff_mask[i] = '0;
      for (int m = 0; m < NMASK; m++) begin
        if (cfg_q[i].msel == MSEL_W'(m + 1)) eff_mask[i] = mask_q[m];
      end
    end
  end
endmodule

// File: rtl/mbrb_match.sv
module mbrb_match
  import mbrb_pkg::*;
#(
  parameter int NBUF = 16,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic [TYPE_W-1:0] btype    [NBUF],
  input  logic [ID_W-1:0]   bid      [NBUF],
  input  logic [MSEL_W-1:0] bmsel    [NBUF],
  input  logic [ID_W-1:0]   eff_mask [NBUF],
  input  logic [ID_W-1:0]   rx_id,
  output logic [NBUF-1:0]   member
);
  logic [NBUF-1:0]   hit;
  logic [IDX_W-1:0]  win;
  logic [TYPE_W-1:0] win_type;
  logic [ID_W-1:0]   win_id;
  logic [MSEL_W-1:0] win_msel;
  logic [ID_W-1:0]   win_mask;
  logic              hit_any;

  // per-buffer acceptance
  for (genvar i = 0; i < NBUF; i++) begin : g_hit
    assign hit[i] = (btype[i] != '0) &&
                    (((rx_id ^ bid[i]) & ~eff_mask[i]) == '0);
  end

  // lowest-numbered accepting buffer names the receiving group
  always_comb begin
    win = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (hit[i]) win = IDX_W'(i);
    end
  end

  assign hit_any  = |hit;
  assign win_type = btype[win];
  assign win_id   = bid[win];
  assign win_msel = bmsel[win];
  assign win_mask = eff_mask[win];

  // buffers sharing the winner's type, selector and masked identifier
  for (genvar j = 0; j < NBUF; j++) begin : g_mem
    assign member[j] = hit_any &&
                       (btype[j] == win_type) &&
                       (bmsel[j] == win_msel) &&
                       (((bid[j] ^ win_id) & ~win_mask) == '0);
  end
endmodule

// File: rtl/mbrb_pick.sv
module mbrb_pick #(
  parameter int NBUF = 16
) (
  input  logic [NBUF-1:0] member,
  input  logic [NBUF-1:0] dn,
  output logic [NBUF-1:0] sel
);
  logic [NBUF-1:0] above;
  logic [NBUF-1:0] cand;
  logic            acc;

  // above[j]: some group buffer with a higher index holds data
  always_comb begin
    acc = 1'b0;
    for (int j = NBUF - 1; j >= 0; j--) begin
      above[j] = acc;
      acc      = acc | (member[j] & dn[j]);
    end
  end

  assign cand = member & ~dn & ~above;
  assign sel  = cand & (~cand + NBUF'(1));
endmodule

// File: rtl/mbrb_store.sv
module mbrb_store
  import mbrb_pkg::*;
#(
  parameter int NBUF   = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [NBUF-1:0]   sel,
  input  logic [NBUF-1:0]   dn_clr,
  input  logic [NBUF-1:0]   ie_vec,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [DATA_W-1:0] rx_data,
  output logic [NBUF-1:0]   dn_q,
  output logic [NBUF-1:0]   irq_q,
  output logic [ID_W-1:0]   st_id   [NBUF],
  output logic [LEN_W-1:0]  st_len  [NBUF],
  output logic [DATA_W-1:0] st_data [NBUF]
);
  logic [NBUF-1:0] we;
  logic [NBUF-1:0] dn_d;
  logic [NBUF-1:0] irq_d;

  // next-state: a store sets its flag after any clear is applied
  always_comb begin
    we    = rx_valid ? sel : '0;
    dn_d  = (dn_q & ~dn_clr) | we;
    irq_d = we & ie_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_q  <= '0;
      irq_q <= '0;
    end else begin
      dn_q  <= dn_d;
      irq_q <= irq_d;
    end
  end

  // payload storage, enabled per buffer
  for (genvar j = 0; j < NBUF; j++) begin : g_mem
    always_ff @(posedge clk) begin
      if (we[j]) begin
        st_id[j]   <= rx_id;
        st_len[j]  <= rx_len;
        st_data[j] <= rx_data;
      end
    end
  end
endmodule

// File: rtl/mbrb_rx_alloc.sv
module mbrb_rx_alloc
  import mbrb_pkg::*;
#(
  parameter int NBUF       = 16,
  parameter int NMASK      = 4,
  parameter int DATA_BYTES = 8,
  localparam int IDX_W  = $clog2(NBUF),
  localparam int MIDX_W = (NMASK > 1) ? $clog2(NMASK) : 1,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [MSEL_W-1:0] cfg_msel,
  input  logic              cfg_ie,
  input  logic              mask_we,
  input  logic [MIDX_W-1:0] mask_idx,
  input  logic [ID_W-1:0]   mask_val,
  input  logic [NBUF-1:0]   dn_clr,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ID_W-1:0]   rd_id,
  output logic [LEN_W-1:0]  rd_len,
  output logic [DATA_W-1:0] rd_data,
  output logic [NBUF-1:0]   dn_vec,
  output logic [NBUF-1:0]   rx_irq
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  bcfg_t             cfg_in;
  logic [TYPE_W-1:0] btype    [NBUF];
  logic [ID_W-1:0]   bid      [NBUF];
  logic [MSEL_W-1:0] bmsel    [NBUF];
  logic [ID_W-1:0]   eff_mask [NBUF];
  logic [NBUF-1:0]   ie_vec;
  logic [NBUF-1:0]   member;
  logic [NBUF-1:0]   sel;
  logic [ID_W-1:0]   st_id    [NBUF];
  logic [LEN_W-1:0]  st_len   [NBUF];
  logic [DATA_W-1:0] st_data  [NBUF];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign cfg_in = '{btype: cfg_type, id: cfg_id, msel: cfg_msel, ie: cfg_ie};

  mbrb_cfg_regs #(.NBUF(NBUF), .NMASK(NMASK)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_in   (cfg_in),
    .mask_we  (mask_we),
    .mask_idx (mask_idx),
    .mask_val (mask_val),
    .btype    (btype),
    .bid      (bid),
    .bmsel    (bmsel),
    .eff_mask (eff_mask),
    .ie_vec   (ie_vec)
  );

  mbrb_match #(.NBUF(NBUF)) u_match (
    .btype    (btype),
    .bid      (bid),
    .bmsel    (bmsel),
    .eff_mask (eff_mask),
    .rx_id    (rx_id),
    .member   (member)
  );

  mbrb_pick #(.NBUF(NBUF)) u_pick (
    .member (member),
    .dn     (dn_vec),
    .sel    (sel)
  );

  mbrb_store #(.NBUF(NBUF), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_valid (rx_valid),
    .sel      (sel),
    .dn_clr   (dn_clr),
    .ie_vec   (ie_vec),
    .rx_id    (rx_id),
    .rx_len   (rx_len),
    .rx_data  (rx_data),
    .dn_q     (dn_vec),
    .irq_q    (rx_irq),
    .st_id    (st_id),
    .st_len   (st_len),
    .st_data  (st_data)
  );

  assign rd_id   = st_id[rd_idx];
  assign rd_len  = st_len[rd_idx];
  assign rd_data = st_data[rd_idx];
endmodule

// File: rtl/mbrb_rx_alloc_chk.sv
module mbrb_rx_alloc_chk #(
  parameter int NBUF   = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [NBUF-1:0]   dn_vec,
  input logic [NBUF-1:0]   rx_irq,
  input logic [DATA_W-1:0] st_data [NBUF]
);
  // R1: flags come out of reset clear
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dn_vec == '0 && rx_irq == '0));

  // R4: a single frame fills at most one buffer
  p_one_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dn_vec & ~$past(dn_vec)) <= 1);

  // R9: at most one completion pulse, only after a strobe, on a flagged buffer
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_irq));
  p_irq_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_irq) |-> $past(rx_valid));
  p_irq_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq & ~dn_vec) == '0);

  for (genvar j = 0; j < NBUF; j++) begin : g_buf
    // R4: a flag only rises in response to a frame strobe
    p_rise_after_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_vec[j]) |-> $past(rx_valid));
    // R11: a flagged buffer keeps its payload
    p_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dn_vec[j]) |-> $stable(st_data[j]));
  end
endmodule

bind mbrb_rx_alloc mbrb_rx_alloc_chk #(.NBUF(NBUF), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rx_valid (rx_valid),
  .dn_vec   (dn_vec),
  .rx_irq   (rx_irq),
  .st_data  (st_data)
);

// File: tb/mbrb_rx_alloc_bench.sv
`timescale 1ns/1ps
module mbrb_rx_alloc_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [2:0]  cfg_type;
  logic [10:0] cfg_id;
  logic [2:0]  cfg_msel;
  logic        cfg_ie;
  logic        mask_we;
  logic [1:0]  mask_idx;
  logic [10:0] mask_val;
  logic [15:0] dn_clr;
  logic        rx_valid;
  logic [10:0] rx_id;
  logic [3:0]  rx_len;
  logic [63:0] rx_data;
  logic [3:0]  rd_idx;
  logic [10:0] rd_id;
  logic [3:0]  rd_len;
  logic [63:0] rd_data;
  logic [15:0] dn_vec;
  logic [15:0] rx_irq;

  typedef struct {
    int          idx;
    logic [15:0] irq;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic        smp_valid = 0;
  logic [15:0] prev_dn = '0;
  logic [15:0] ie_tab  = '0;
  logic [10:0] mdl_id   [16];
  logic [3:0]  mdl_len  [16];
  logic [63:0] mdl_data [16];
  int          seq = 0;

  mbrb_rx_alloc u_mbrb_rx_alloc (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_type(cfg_type), .cfg_id(cfg_id),
    .cfg_msel(cfg_msel), .cfg_ie(cfg_ie),
    .mask_we(mask_we), .mask_idx(mask_idx), .mask_val(mask_val),
    .dn_clr(dn_clr),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len), .rx_data(rx_data),
    .rd_idx(rd_idx), .rd_id(rd_id), .rd_len(rd_len), .rd_data(rd_data),
    .dn_vec(dn_vec), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) smp_valid <= rx_valid;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare the flag rise and interrupt against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic [15:0] rise;
        rise    = dn_vec & ~prev_dn;
        prev_dn = dn_vec;
        if (smp_valid) begin
          if (expq.size() == 0) begin
            check(1'b0, "R4 queue empty", 64'(rise), 64'(0));
          end else begin
            exp_t e;
            logic [15:0] er;
            e  = expq.pop_front();
            er = (e.idx < 0) ? 16'h0 : (16'h1 << e.idx);
            check(rise == er, {e.tag, " store target"}, 64'(rise), 64'(er));
            check(rx_irq == e.irq, {"R9 ", e.tag, " irq"}, 64'(rx_irq), 64'(e.irq));
          end
        end else if (rise != 0 || rx_irq != 0) begin
          check(1'b0, "R4 unsolicited store", 64'({rise, rx_irq}), 64'(0));
        end
      end
    end
  end

  task automatic cfg_buf(input int idx, input int typ, input int id, input int msel,
                         input bit ie);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_type = 3'(typ); cfg_id = 11'(id);
    cfg_msel = 3'(msel); cfg_ie = ie;
    ie_tab[idx] = ie;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input int idx, input int val);
    @(negedge clk);
    mask_we = 1'b1; mask_idx = 2'(idx); mask_val = 11'(val);
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic clr(input logic [15:0] v);
    @(negedge clk);
    dn_clr = v;
    @(negedge clk);
    dn_clr = '0;
  endtask

  // driver: one frame, expected outcome pushed to the scoreboard
  task automatic send(input int id, input int exp_idx, input string tag,
                      input logic [15:0] clrv = '0);
    exp_t e;
    @(negedge clk);
    seq++;
    rx_valid = 1'b1;
    rx_id    = 11'(id);
    rx_len   = 4'(seq % 9);
    rx_data  = {32'hC0DE0000 | 32'(seq), 21'h0, 11'(id)};
    dn_clr   = clrv;
    e.idx = exp_idx;
    e.irq = (exp_idx >= 0 && ie_tab[exp_idx]) ? (16'h1 << exp_idx) : 16'h0;
    e.tag = tag;
    expq.push_back(e);
    if (exp_idx >= 0) begin
      mdl_id[exp_idx]   = rx_id;
      mdl_len[exp_idx]  = rx_len;
      mdl_data[exp_idx] = rx_data;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    dn_clr   = '0;
  endtask

  task automatic chk_buf(input int idx, input string tag);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1;
    check(rd_id == mdl_id[idx], {tag, " id"}, 64'(rd_id), 64'(mdl_id[idx]));
    check(rd_len == mdl_len[idx], {tag, " len"}, 64'(rd_len), 64'(mdl_len[idx]));
    check(rd_data == mdl_data[idx], {tag, " data"}, rd_data, mdl_data[idx]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_type = 0; cfg_id = 0; cfg_msel = 0;
    cfg_ie = 0; mask_we = 0; mask_idx = 0; mask_val = 0; dn_clr = '0;
    rx_valid = 0; rx_id = 0; rx_len = 0; rx_data = '0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared state, and an all-zero configuration stores nothing
    check(dn_vec == '0, "R1 flags after reset", 64'(dn_vec), 64'(0));
    check(rx_irq == '0, "R1 irq after reset", 64'(rx_irq), 64'(0));
    send(0, -1, "R1 unconfigured drop");

    set_mask(0, 11'h00F);
    set_mask(1, 11'h0FF);
    cfg_buf(0, 3, 11'h300, 1, 1'b1);
    cfg_buf(1, 3, 11'h30A, 1, 1'b0);
    for (int b = 2; b < 6; b++) cfg_buf(b, 1, 11'h120, 0, (b >= 4));
    cfg_buf(6, 4, 11'h500, 2, 1'b1);
    cfg_buf(8, 2, 11'h120, 0, 1'b1);
    cfg_buf(9, 2, 11'h120, 0, 1'b1);
    cfg_buf(10, 5, 11'h5AB, 0, 1'b1);
    cfg_buf(14, 0, 11'h7FF, 0, 1'b1);

    // R2: type-0 buffer ignores its identifier
    send(11'h7FF, -1, "R2 unused buffer");

    // R3: masked matching and masked grouping
    send(11'h310, -1, "R3 outside mask");
    send(11'h305, 0, "R3 masked hit");
    send(11'h30F, 1, "R3 raw id differs, same group");
    chk_buf(1, "R11 masked store");

    // R4: ascending fill with interrupts on the top two buffers
    send(11'h120, 2, "R4 fill 1");
    send(11'h120, 3, "R4 fill 2");
    send(11'h120, 4, "R4 fill 3 near full");
    send(11'h120, 5, "R4 fill 4 full");
    chk_buf(3, "R11 fill 2 contents");

    // R5/R7: full group drops, the other type keeps its space
    send(11'h120, -1, "R7 no spill to other type");
    clr(16'h0004);
    send(11'h120, -1, "R5 no wrap after low clear");
    check(dn_vec[9:8] == 2'b00, "R7 other group empty", 64'(dn_vec[9:8]), 64'(0));

    // R6: all flags cleared restarts at the lowest buffer
    clr(16'h0038);
    check(dn_vec[5:2] == 4'b0000, "R10 group flags cleared", 64'(dn_vec[5:2]), 64'(0));
    send(11'h120, 2, "R6 restart at lowest");
    chk_buf(2, "R11 restart contents");
    send(11'h120, 3, "R4 next above");
    clr(16'h0004);
    send(11'h120, 4, "R4 skip freed lower buffer");
    chk_buf(4, "R11 after middle clear");

    // R8: overlapping groups, lowest matching buffer wins
    send(11'h5AB, 6, "R8 lowest matching group");
    send(11'h5AB, -1, "R8 full winner drops");
    clr(16'h0040);
    send(11'h5AC, 6, "R8 masked winner again");

    // R10: store and clear of the same flag in one cycle
    clr(16'h0003);
    send(11'h300, 0, "R10 set beats clear", 16'h0001);
    check(dn_vec[0] == 1'b1, "R10 flag held", 64'(dn_vec[0]), 64'(1));
    chk_buf(0, "R11 collision contents");

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R4 scoreboard drained", 64'(expq.size()), 64'(0));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule